// File: doc/BRIEF.md
# Rectangle Fill and Block Copy Engine

The engine runs one rectangle operation at a time on pixel memory laid out as a linear frame buffer. It can fill a rectangle with one colour. Lines are handled as rectangles that are one pixel wide or one pixel high. It can also copy a source rectangle onto a destination rectangle, in one of three ways:

- combining source and destination bits through a programmable raster operation;
- skipping source pixels that match a key colour;
- mixing source and destination with a global alpha.

The source and the destination each have their own base address and row pitch. Packed areas and strided areas are handled in the same way.

A command is presented on the command ports together with a one-cycle `start` pulse. The engine reads pixels through a read port whose data returns in the same cycle. It writes through a write port that memory commits on the next rising edge. When the destination lies above the source in memory, the engine walks the rectangle from bottom-right to top-left, so an overlapping move gives the same result as a copy taken from an untouched source.

Top module: `rect_engine`

## Requirements
- R1: After reset, `busy`, `done`, `finished`, `rd_en` and `wr_en` are all low.
- R2: Mode 0 (fill) writes `colour` to every pixel of the destination rectangle. It makes one write per clock. `done` rises exactly `width*height+1` clock edges after the edge that accepts `start`, counting that edge as 1.
- R3: A rectangle with width 1 (vertical line) or height 1 (horizontal line), including a 4095-pixel horizontal line, writes exactly the pixels of that line.
- R4: Pixel (x, y) of an area is at address `base + y*pitch + x`. The source and the destination use their own base and pitch independently.
- R5: Mode 1 (raster copy) writes, for every bit i, the value `rop[2*s + d]`, where s is source bit i and d is the original destination bit i.
- R6: Mode 2 (keyed copy) writes the source pixel unchanged, except that a source pixel equal to `key` causes no write to its destination pixel.
- R7: Mode 3 (alpha copy) writes `(s*alpha + d*(255-alpha)) >> 8` for every 8-bit channel, where s is the source channel and d is the original destination channel.
- R8: For copy modes, when `dst_base > src_base`, pixels are processed last-row-first and right-to-left. With equal pitches, an overlapping copy then yields the same result as a copy taken from a snapshot of the source.
- R9: A copy takes two cycles per pixel, so `done` rises `2*width*height+1` edges after acceptance. `done` is a single-cycle pulse that coincides with `busy` falling. `finished` stays high from then until the next accepted command.
- R10: A command with width 0 or height 0 performs no writes and pulses `done` on the edge after acceptance.
- R11: A `start` pulse while `busy` is high is ignored. The running command completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Accept the command on the command ports when idle |
| mode | input | 2 | 0 fill, 1 raster copy, 2 keyed copy, 3 alpha copy |
| rop | input | 4 | Raster truth table indexed by {source bit, destination bit} |
| colour | input | PIX_W | Fill colour |
| key | input | PIX_W | Transparency key for mode 2 |
| alpha | input | 8 | Global source weight for mode 3 |
| src_base | input | ADDR_W | Source rectangle top-left address |
| src_pitch | input | ADDR_W | Source row pitch in pixels |
| dst_base | input | ADDR_W | Destination rectangle top-left address |
| dst_pitch | input | ADDR_W | Destination row pitch in pixels |
| width | input | DIM_W | Rectangle width in pixels |
| height | input | DIM_W | Rectangle height in pixels |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle pulse when a command completes |
| finished | output | 1 | Sticky completion flag, cleared by the next command |
| rd_en | output | 1 | Read request |
| rd_addr | output | ADDR_W | Read address |
| rd_data | input | PIX_W | Read data, valid in the same cycle as rd_addr |
| wr_en | output | 1 | Write strobe |
| wr_addr | output | ADDR_W | Write address |
| wr_data | output | PIX_W | Write data |

## Verification
The bench builds the engine with `PIX_W=24`, `ADDR_W=12` and `DIM_W=12`. A 4096-word memory model therefore covers the whole address space. This lets one 4095-pixel horizontal line, the widest command, run in full and be checked pixel by pixel.

Three 8-bit channels exercise the per-channel blend and carry boundaries. Full 12-bit dimensions reach the width limit.

Random commands keep source and destination in separate halves of memory. Directed commands cover:
- overlap in both directions with equal pitch;
- zero sizes;
- a start pulse issued while the engine is busy.

// File: rtl/rect_engine.sv
module rect_engine #(
  parameter int PIX_W  = 24,
  parameter int ADDR_W = 24,
  parameter int DIM_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        mode,
  input  logic [3:0]        rop,
  input  logic [PIX_W-1:0]  colour,
  input  logic [PIX_W-1:0]  key,
  input  logic [7:0]        alpha,
  input  logic [ADDR_W-1:0] src_base,
  input  logic [ADDR_W-1:0] src_pitch,
  input  logic [ADDR_W-1:0] dst_base,
  input  logic [ADDR_W-1:0] dst_pitch,
  input  logic [DIM_W-1:0]  width,
  input  logic [DIM_W-1:0]  height,
  output logic              busy,
  output logic              done,
  output logic              finished,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [PIX_W-1:0]  rd_data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [PIX_W-1:0]  wr_data
);
  localparam int CH = PIX_W / 8;

  typedef enum logic [1:0] {S_IDLE, S_SRC, S_PIX} st_t;
  st_t st;

  logic [1:0]        m_q;
  logic [3:0]        rop_q;
  logic [PIX_W-1:0]  col_q, key_q, src_q;
  logic [7:0]        a_q;
  logic [ADDR_W-1:0] sb_q, sp_q, db_q, dp_q;
  logic [DIM_W-1:0]  w_q, h_q, x, y;
  logic              rev;

  wire copy   = (m_q != 2'd0);
  wire rev_n  = (mode != 2'd0) && (dst_base > src_base);
  wire zero_n = (width == '0) || (height == '0);
  wire last_x = rev ? (x == '0) : (x == w_q - DIM_W'(1));
  wire last_y = rev ? (y == '0) : (y == h_q - DIM_W'(1));

  wire [ADDR_W-1:0] s_addr = sb_q + ADDR_W'(y) * sp_q + ADDR_W'(x);
  wire [ADDR_W-1:0] d_addr = db_q + ADDR_W'(y) * dp_q + ADDR_W'(x);

  logic [PIX_W-1:0] rop_px, mix_px;
  always_comb
    for (int i = 0; i < PIX_W; i++) rop_px[i] = rop_q[{src_q[i], rd_data[i]}];

  for (genvar c = 0; c < CH; c++) begin : g_ch
    wire [15:0] acc = 16'(src_q[c*8 +: 8]) * 16'(a_q)
                    + 16'(rd_data[c*8 +: 8]) * 16'(8'd255 - a_q);
    assign mix_px[c*8 +: 8] = acc[15:8];
  end

  assign busy    = (st != S_IDLE);
  assign rd_en   = (st == S_SRC) || (st == S_PIX && (m_q == 2'd1 || m_q == 2'd3));
  assign rd_addr = (st == S_SRC) ? s_addr : d_addr;
  assign wr_en   = (st == S_PIX) && !(m_q == 2'd2 && src_q == key_q);
  assign wr_addr = d_addr;
  always_comb
    case (m_q)
      2'd0:    wr_data = col_q;
      2'd1:    wr_data = rop_px;
      2'd2:    wr_data = src_q;
      default: wr_data = mix_px;
    endcase

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; done <= 1'b0; finished <= 1'b0;
      m_q <= '0; rop_q <= '0; col_q <= '0; key_q <= '0; a_q <= '0; src_q <= '0;
      sb_q <= '0; sp_q <= '0; db_q <= '0; dp_q <= '0;
      w_q <= '0; h_q <= '0; x <= '0; y <= '0; rev <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          if (zero_n) begin
            done <= 1'b1; finished <= 1'b1;
          end else begin
            finished <= 1'b0;
            m_q <= mode; rop_q <= rop; col_q <= colour; key_q <= key; a_q <= alpha;
            sb_q <= src_base; sp_q <= src_pitch; db_q <= dst_base; dp_q <= dst_pitch;
            w_q <= width; h_q <= height; rev <= rev_n;
            x <= rev_n ? width - DIM_W'(1) : '0;
            y <= rev_n ? height - DIM_W'(1) : '0;
            st <= (mode == 2'd0) ? S_PIX : S_SRC;
          end
        end
        S_SRC: begin
          src_q <= rd_data;
          st <= S_PIX;
        end
        default: begin
          if (last_x && last_y) begin
            st <= S_IDLE; done <= 1'b1; finished <= 1'b1;
          end else begin
            st <= copy ? S_SRC : S_PIX;
            if (last_x) begin
              x <= rev ? w_q - DIM_W'(1) : '0;
              y <= rev ? y - DIM_W'(1) : y + DIM_W'(1);
            end else begin
              x <= rev ? x - DIM_W'(1) : x + DIM_W'(1);
            end
          end
        end
      endcase
    end
  end

  AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !wr_en && !rd_en); // R1
  AST_DONE_PULSE:    assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R9
  AST_DONE_ENDS:     assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy && finished); // R9
  AST_COPY_PAIRED:   assert property (@(posedge clk) disable iff (!rst_n) wr_en && copy |-> $past(st == S_SRC)); // R9
  AST_FILL_STREAM:   assert property (@(posedge clk) disable iff (!rst_n) busy && !copy |-> wr_en); // R2
  AST_ZERO_SIZE:     assert property (@(posedge clk) disable iff (!rst_n) !busy && start && zero_n |=> !busy && done); // R10
  AST_BUSY_HOLDS:    assert property (@(posedge clk) disable iff (!rst_n) busy && start |=> $stable(m_q) && $stable(w_q)); // R11
endmodule

// File: tb/tb_rect_engine.sv
module tb_rect_engine;
  localparam int PW = 24, AW = 12, DW = 12, MEM = 4096;
  localparam logic [PW-1:0] KEYV = 24'h123456;

  logic clk = 0, rst_n = 0, start = 0;
  logic [1:0] mode = 0; logic [3:0] rop = 0; logic [7:0] alpha = 0;
  logic [PW-1:0] colour = 0, key = 0;
  logic [AW-1:0] src_base = 0, src_pitch = 0, dst_base = 0, dst_pitch = 0;
  logic [DW-1:0] width = 0, height = 0;
  logic busy, done, finished, rd_en, wr_en;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [PW-1:0] rd_data, wr_data;

  logic [PW-1:0] mem [MEM];
  logic [PW-1:0] old [MEM];
  logic [PW-1:0] expm [MEM];
  int wcount = 0;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  rect_engine #(.PIX_W(PW), .ADDR_W(AW), .DIM_W(DW)) dut (.*);

  assign rd_data = mem[rd_addr];
  always @(posedge clk) if (wr_en) begin mem[wr_addr] <= wr_data; wcount <= wcount + 1; end

  initial begin
    #(20 * 190000);
    bad++; total++;
    $display("FAIL watchdog: run did not complete");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s: actual=%0h expected=%0h", req, act, exp); end
  endtask

  function automatic logic [PW:0] model(input logic [1:0] m, input logic [3:0] r,
      input logic [PW-1:0] c, input logic [PW-1:0] k, input logic [7:0] a,
      input logic [PW-1:0] s, input logic [PW-1:0] d);
    logic [PW-1:0] v;
    case (m)
      2'd0: return {1'b1, c};
      2'd1: begin for (int i = 0; i < PW; i++) v[i] = r[2*s[i] + d[i]]; return {1'b1, v}; end
      2'd2: return {s != k, s};
      default: begin
        for (int ch = 0; ch < PW/8; ch++)
          v[ch*8 +: 8] = 8'((int'(s[ch*8 +: 8]) * a + int'(d[ch*8 +: 8]) * (255 - a)) >> 8);
        return {1'b1, v};
      end
    endcase
  endfunction

  task automatic run(input string req, input logic [1:0] m, input logic [3:0] r,
      input logic [PW-1:0] c, input logic [7:0] a, input int sb, input int sp,
      input int db, input int dp, input int w, input int h, input bit poke);
    int ew = 0, cyc = 0, mism = 0, exp_cyc;
    logic [PW:0] res;
    for (int i = 0; i < MEM; i++) begin old[i] = mem[i]; expm[i] = mem[i]; end
    for (int yy = 0; yy < h; yy++)
      for (int xx = 0; xx < w; xx++) begin
        res = model(m, r, c, KEYV, a, old[(sb + yy*sp + xx) % MEM], old[(db + yy*dp + xx) % MEM]);
        if (res[PW]) begin expm[(db + yy*dp + xx) % MEM] = res[PW-1:0]; ew++; end
      end
    exp_cyc = (w == 0 || h == 0) ? 1 : (m == 0 ? w*h + 1 : 2*w*h + 1);
    wcount = 0;
    mode = m; rop = r; colour = c; key = KEYV; alpha = a;
    src_base = AW'(sb); src_pitch = AW'(sp); dst_base = AW'(db); dst_pitch = AW'(dp);
    width = DW'(w); height = DW'(h);
    start = 1;
    @(negedge clk); start = 0; cyc = 1;
    while (!done && cyc < 20000) begin
      if (poke && cyc == 3) begin
        start = 1; mode = 0; colour = 24'hFFFFFF; width = 2; height = 2;
      end else start = 0;
      @(negedge clk); cyc++;
    end
    start = 0;
    check(cyc == exp_cyc, {req, " latency"}, cyc, exp_cyc);
    check(!busy && finished, {req, " completion state"}, {busy, finished}, 2'b01);
    @(negedge clk);
    check(!done && finished, {req, " done single pulse / finished sticky"}, {done, finished}, 2'b01);
    check(wcount == ew, {req, " write count"}, wcount, ew);
    for (int i = 0; i < MEM; i++) if (mem[i] !== expm[i]) begin
      if (mism == 0) check(0, {req, " memory"}, mem[i], expm[i]);
      mism++;
    end
    check(mism == 0, {req, " memory mismatches"}, mism, 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < MEM; i++) mem[i] = ($urandom % 4 == 0) ? KEYV : PW'($urandom);
    repeat (3) @(negedge clk);
    check(!busy && !done && !finished && !rd_en && !wr_en, "R1 reset",
          {busy, done, finished, rd_en, wr_en}, 0);
    rst_n = 1;
    @(negedge clk);

    run("R2 fill 1x1", 0, 0, 24'hA5A5A5, 0, 0, 0, 2100, 10, 1, 1, 0);
    run("R2 R4 fill strided", 0, 0, 24'h00FF00, 0, 0, 0, 2200, 37, 9, 6, 0);
    run("R3 horizontal line 4095", 0, 0, 24'h0F0F0F, 0, 0, 0, 0, 4096, 4095, 1, 0);
    for (int i = 0; i < MEM; i++) mem[i] = ($urandom % 4 == 0) ? KEYV : PW'($urandom);
    run("R3 vertical line", 0, 0, 24'h333333, 0, 0, 0, 2050, 50, 1, 30, 0);
    run("R5 rop xor", 1, 4'b0110, 0, 0, 10, 20, 2500, 33, 7, 5, 0);
    run("R5 rop not-src", 1, 4'b0011, 0, 0, 40, 16, 2600, 16, 5, 4, 0);
    run("R6 keyed copy", 2, 0, 0, 0, 300, 12, 3000, 18, 10, 8, 0);
    run("R7 alpha 0", 3, 0, 0, 8'd0, 500, 10, 3300, 11, 6, 3, 0);
    run("R7 alpha 255", 3, 0, 0, 8'd255, 600, 10, 3400, 10, 6, 3, 0);
    run("R10 zero width", 0, 0, 24'h111111, 0, 0, 0, 2100, 10, 0, 5, 0);
    run("R10 zero height", 1, 4'b1100, 0, 0, 10, 10, 2100, 10, 5, 0, 0);
    run("R8 overlap up", 1, 4'b1100, 0, 0, 100, 20, 103, 20, 8, 5, 0);
    run("R8 overlap rows", 3, 0, 0, 8'd77, 700, 16, 716, 16, 10, 4, 0);
    run("R8 overlap down forward", 1, 4'b1100, 0, 0, 903, 20, 900, 20, 8, 5, 0);
    run("R11 start while busy", 1, 4'b1010, 0, 0, 1200, 9, 3600, 9, 6, 4, 1);

    for (int n = 0; n < 40; n++) begin
      int w = 1 + $urandom % 16, h = 1 + $urandom % 8;
      run("R4 R9 random", 2'($urandom), 4'($urandom), PW'($urandom), 8'($urandom),
          $urandom % 1000, w + $urandom % 20, 2048 + $urandom % 1000, w + $urandom % 20,
          w, h, 0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule